// File: doc/BRIEF.md
# Burst Crossbar Switch

This block is a sixteen-port, non-blocking crossbar that moves bursts of flits from any input port to any output port. Every flit holds a 36-bit payload, an end-of-burst marker and a 4-bit port field. On the way in, that field holds the destination output. On the way out, the switch overwrites it with the number of the input the burst came from. The receiver can therefore reply without extra header decode.

The route is taken from the first flit of a burst and kept until the flit marked as last has been accepted. Each output serves its competing inputs in round-robin order. It makes a new choice only between bursts, so flits of different bursts never mix on one output. Flow control is valid/ready at both edges. A stalled output holds its registered flit and lowers ready on the one input feeding it. Input/output pairs that do not share a port run in parallel. Each output has one register stage and there is no other buffering.

Top module: `burst_xbar`

## Requirements
- R1: While reset is asserted (rst_n low) every out_valid bit is 0.
- R2: A flit accepted on input s (in_valid and in_ready both high at a rising edge) of a burst whose first flit carried in_dest = d appears on output d one clock later or later, with out_data equal to in_data and out_last equal to in_last.
- R3: The in_dest value of the second and later flits of a burst is ignored; the path chosen by the first flit holds until the flit with in_last = 1 is accepted.
- R4: Once an output has presented a flit with out_last = 0 from input s, every following flit on that output comes from input s until a flit with out_last = 1 has been taken.
- R5: out_src on output d equals the number (0 to 15) of the input that sent the flit.
- R6: Each output grants bursts in round-robin order. After reset its priority starts at input 0. After a burst from input k wins, the search starts at input k+1 (wrapping from 15 to 0).
- R7: Every accepted flit is delivered exactly once, and flits from one input to one output leave in the order they were accepted.
- R8: While out_valid is 1 and out_ready is 0, the output holds out_valid, out_data, out_last and out_src unchanged. An input is never ready unless it is valid. At most one input is granted to a given output in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 16 | Flit present on each input |
| in_data | input | 16x36 | Payload per input |
| in_last | input | 16 | Last-flit marker per input |
| in_dest | input | 16x4 | Destination output, read from the first flit only |
| in_ready | output | 16 | Input flit accepted this cycle |
| out_valid | output | 16 | Flit present on each output |
| out_data | output | 16x36 | Payload per output |
| out_last | output | 16 | Last-flit marker per output |
| out_src | output | 16x4 | Number of the sending input |
| out_ready | input | 16 | Downstream can take the flit |

## Verification
The bench sends three inputs at one output at the same moment and checks that they are served in the order 0,1,2,0,1,2. An arbiter that does not move its priority would serve input 0 twice first. Later flits of each burst carry a wrong destination field, so a design that routes every flit by its own field sends the rest of the burst to the wrong port. Eight inputs contend for two outputs with pseudo-random backpressure. A design that re-arbitrates in the middle of a burst shows interleaved sources. One that does not hold its output register under stall loses or changes flits, and the per-pair queues catch this as a drop, a duplicate or a reordering.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic {
    EG_IDLE   = 1'b0,
    EG_LOCKED = 1'b1
  } eg_state_e;
endpackage

// File: rtl/xbar_ingress.sv
// Per-input route holder: captures the destination of a burst's first flit
// and keeps it until the last flit has been accepted.
module xbar_ingress #(
  parameter int NPORT = 16,
  localparam int IDW = $clog2(NPORT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flit_valid,
  input  logic           flit_last,
  input  logic           flit_ready,
  input  logic [IDW-1:0] dest_raw,
  output logic [IDW-1:0] dest_eff
);
  logic           mid_q, mid_d;
  logic [IDW-1:0] route_q, route_d;
  logic           xfer;

  assign xfer     = flit_valid && flit_ready;
  assign dest_eff = mid_q ? route_q : dest_raw;

  always_comb begin
    mid_d   = mid_q;
    route_d = route_q;
    if (xfer) begin
      mid_d = !flit_last;
      if (!mid_q) route_d = dest_raw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q   <= 1'b0;
      route_q <= '0;
    end else if (xfer) begin
      mid_q   <= mid_d;
      route_q <= route_d;
    end
  end
endmodule

// File: rtl/xbar_rr_pick.sv
// Combinational round-robin search starting at ptr.
module xbar_rr_pick #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (!any && req[j]) begin
        any = 1'b1;
        idx = IW'(j);
      end
    end
  end
endmodule

// File: rtl/xbar_egress.sv
// One output port: request decode, burst lock, round-robin choice and the
// output register stage.
module xbar_egress
  import xbar_pkg::*;
#(
  parameter int NPORT = 16,
  parameter int DW    = 36,
  parameter int MY_ID = 0,
  localparam int IDW = $clog2(NPORT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          in_valid,
  input  logic [NPORT-1:0]          in_last,
  input  logic [NPORT-1:0][IDW-1:0] dest_eff,
  input  logic [NPORT-1:0][DW-1:0]  in_data,
  input  logic                      out_ready,
  output logic [NPORT-1:0]          gnt,
  output logic                      out_valid,
  output logic [DW-1:0]             out_data,
  output logic                      out_last,
  output logic [IDW-1:0]            out_src
);
  eg_state_e      state_q, state_d;
  logic [IDW-1:0] owner_q, owner_d;
  logic [IDW-1:0] ptr_q, ptr_d;
  logic [NPORT-1:0] req;
  logic           pick_any;
  logic [IDW-1:0] pick_idx;
  logic [IDW-1:0] sel;
  logic           sel_ok, take, fire;
  logic           ov_q, ov_d;
  logic [DW-1:0]  od_q;
  logic           ol_q;
  logic [IDW-1:0] os_q;

  always_comb begin
    for (int i = 0; i < NPORT; i++)
      req[i] = in_valid[i] && (dest_eff[i] == IDW'(MY_ID));
  end

  xbar_rr_pick #(.N(NPORT)) u_pick (
    .req (req),
    .ptr (ptr_q),
    .any (pick_any),
    .idx (pick_idx)
  );

  assign sel    = (state_q == EG_LOCKED) ? owner_q : pick_idx;
  assign sel_ok = (state_q == EG_LOCKED) ? req[owner_q] : pick_any;
  assign take   = !ov_q || out_ready;
  assign fire   = sel_ok && take;

  always_comb begin
    gnt = '0;
    if (fire) gnt[sel] = 1'b1;
  end

  // next-state: lock, owner, pointer
  always_comb begin
    state_d = state_q;
    owner_d = owner_q;
    ptr_d   = ptr_q;
    if (fire) begin
      if (in_last[sel]) begin
        state_d = EG_IDLE;
      end else begin
        state_d = EG_LOCKED;
        owner_d = sel;
      end
      if (state_q == EG_IDLE)
        ptr_d = (sel == IDW'(NPORT - 1)) ? '0 : sel + 1'b1;
    end
  end

  assign ov_d = take ? fire : ov_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EG_IDLE;
      owner_q <= '0;
      ptr_q   <= '0;
    end else if (fire) begin
      state_q <= state_d;
      owner_q <= owner_d;
      ptr_q   <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_q <= 1'b0;
    else        ov_q <= ov_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q <= '0;
      ol_q <= 1'b0;
      os_q <= '0;
    end else if (fire) begin
      od_q <= in_data[sel];
      ol_q <= in_last[sel];
      os_q <= sel;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_last  = ol_q;
  assign out_src   = os_q;
endmodule

// File: rtl/burst_xbar.sv
module burst_xbar #(
  parameter int NPORT = 16,
  parameter int DW    = 36,
  localparam int IDW = $clog2(NPORT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          in_valid,
  input  logic [NPORT-1:0][DW-1:0]  in_data,
  input  logic [NPORT-1:0]          in_last,
  input  logic [NPORT-1:0][IDW-1:0] in_dest,
  output logic [NPORT-1:0]          in_ready,
  output logic [NPORT-1:0]          out_valid,
  output logic [NPORT-1:0][DW-1:0]  out_data,
  output logic [NPORT-1:0]          out_last,
  output logic [NPORT-1:0][IDW-1:0] out_src,
  input  logic [NPORT-1:0]          out_ready
);
  logic [NPORT-1:0][IDW-1:0]   dest_eff;
  logic [NPORT-1:0][NPORT-1:0] gnt_all;  // [output][input]

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    xbar_ingress #(.NPORT(NPORT)) u_ing (
      .clk        (clk),
      .rst_n      (rst_n),
      .flit_valid (in_valid[i]),
      .flit_last  (in_last[i]),
      .flit_ready (in_ready[i]),
      .dest_raw   (in_dest[i]),
      .dest_eff   (dest_eff[i])
    );
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    xbar_egress #(.NPORT(NPORT), .DW(DW), .MY_ID(o)) u_eg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .dest_eff  (dest_eff),
      .in_data   (in_data),
      .out_ready (out_ready[o]),
      .gnt       (gnt_all[o]),
      .out_valid (out_valid[o]),
      .out_data  (out_data[o]),
      .out_last  (out_last[o]),
      .out_src   (out_src[o])
    );
  end

  always_comb begin
    in_ready = '0;
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++)
        in_ready[i] = in_ready[i] | gnt_all[o][i];
  end
endmodule

// File: rtl/burst_xbar_chk.sv
module burst_xbar_chk #(
  parameter int NPORT = 16,
  parameter int DW    = 36,
  localparam int IDW = $clog2(NPORT)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NPORT-1:0]          in_valid,
  input logic [NPORT-1:0]          in_ready,
  input logic [NPORT-1:0]          out_valid,
  input logic [NPORT-1:0][DW-1:0]  out_data,
  input logic [NPORT-1:0]          out_last,
  input logic [NPORT-1:0][IDW-1:0] out_src,
  input logic [NPORT-1:0]          out_ready,
  input logic [NPORT-1:0][NPORT-1:0] gnt_all
);
  // R1: outputs idle while in reset
  always @(posedge clk) begin
    if (!rst_n) p_reset_idle_r1: assert (out_valid == '0);
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_o
    logic           mid_q;
    logic [IDW-1:0] src_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mid_q <= 1'b0;
        src_q <= '0;
      end else if (out_valid[o] && out_ready[o]) begin
        mid_q <= !out_last[o];
        src_q <= out_src[o];
      end
    end

    p_burst_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_q && out_valid[o]) |-> (out_src[o] == src_q));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=>
        (out_valid[o] && $stable(out_data[o]) && $stable(out_last[o]) &&
         $stable(out_src[o])));

    p_one_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_all[o]));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_i
    p_ready_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready[i] |-> in_valid[i]);
  end
endmodule

bind burst_xbar burst_xbar_chk #(.NPORT(NPORT), .DW(DW)) u_chk (.*);

// File: tb/burst_xbar_bench.sv
`timescale 1ns/1ps
module burst_xbar_bench;
  localparam int NP = 16;
  localparam int DW = 36;

  logic clk, rst_n;
  logic [NP-1:0]         in_valid, in_last, in_ready;
  logic [NP-1:0][DW-1:0] in_data;
  logic [NP-1:0][3:0]    in_dest;
  logic [NP-1:0]         out_valid, out_last, out_ready;
  logic [NP-1:0][DW-1:0] out_data;
  logic [NP-1:0][3:0]    out_src;

  burst_xbar u_burst_xbar (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit bp_on = 0;
  bit rec_order = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [40:0] exp_q [NP*NP][$];   // {last, src, data}
  int order_q[$];
  int seq [NP];
  logic [NP-1:0]      mid = '0;
  logic [NP-1:0][3:0] mid_src;
  logic [NP-1:0]      held = '0;
  logic [NP-1:0][40:0] held_v;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor and downstream ready generator
  always @(negedge clk) begin
    if (!rst_n) begin
      out_ready = '1;
    end else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int o = 0; o < NP; o++) begin
        if (held[o])
          check(out_valid[o] && {out_last[o], out_src[o], out_data[o]} == held_v[o],
                "R8", "stalled output changed",
                longint'({out_valid[o], out_last[o], out_src[o], out_data[o]}),
                longint'({1'b1, held_v[o]}));
        out_ready[o] = bp_on ? (lfsr[o] | lfsr[(o + 5) % 16]) : 1'b1;
        held[o] = 1'b0;
        if (out_valid[o]) begin
          if (out_ready[o]) begin
            int key;
            key = int'(out_src[o]) * NP + o;
            if (exp_q[key].size() == 0) begin
              check(0, "R2/R7", "unexpected flit", longint'(out_data[o]), 0);
            end else begin
              logic [40:0] e;
              e = exp_q[key].pop_front();
              check({out_last[o], out_src[o], out_data[o]} == e, "R2/R3/R5/R7",
                    "flit content", longint'({out_last[o], out_src[o], out_data[o]}),
                    longint'(e));
            end
            check(!mid[o] || out_src[o] == mid_src[o], "R4", "burst interleaved",
                  longint'(out_src[o]), longint'(mid_src[o]));
            mid[o] = !out_last[o];
            mid_src[o] = out_src[o];
            if (o == 5 && rec_order && out_last[o]) order_q.push_back(int'(out_src[o]));
          end else begin
            held[o] = 1'b1;
            held_v[o] = {out_last[o], out_src[o], out_data[o]};
          end
        end
      end
    end
  end

  // driver: one burst; later flits carry a wrong destination on purpose (R3)
  task automatic send_burst(input int s, input int d, input int len);
    for (int f = 0; f < len; f++) begin
      @(negedge clk);
      in_valid[s] = 1'b1;
      in_dest[s]  = (f == 0) ? 4'(d) : ~4'(d);
      in_last[s]  = (f == len - 1);
      in_data[s]  = {4'(s), 4'(d), 28'(seq[s])};
      #1;
      while (!in_ready[s]) begin
        @(negedge clk);
        #1;
      end
      exp_q[s*NP + d].push_back({in_last[s], 4'(s), in_data[s]});
      seq[s]++;
    end
  endtask

  task automatic go_idle(input int s);
    @(negedge clk);
    in_valid[s] = 1'b0;
  endtask

  task automatic run_par(input int s);
    for (int b = 1; b <= 4; b++) send_burst(s, (s + 3) % NP, b);
    go_idle(s);
  endtask

  task automatic run_cont(input int s);
    for (int b = 0; b < 4; b++) send_burst(s, ((s + b) % 2 == 0) ? 9 : 10, 3);
    go_idle(s);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = '0; in_last = '0; in_data = '0; in_dest = '0;
    out_ready = '1;
    for (int i = 0; i < NP; i++) seq[i] = 0;
    repeat (3) @(negedge clk);
    check(out_valid == '0, "R1", "out_valid in reset", longint'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == '0, "R1", "out_valid after reset", longint'(out_valid), 0);

    // R6 fairness: three inputs, two single-flit bursts each, to output 5
    rec_order = 1;
    fork
      begin send_burst(0, 5, 1); send_burst(0, 5, 1); go_idle(0); end
      begin send_burst(1, 5, 1); send_burst(1, 5, 1); go_idle(1); end
      begin send_burst(2, 5, 1); send_burst(2, 5, 1); go_idle(2); end
    join
    repeat (5) @(negedge clk);
    rec_order = 0;
    check(order_q.size() == 6, "R6", "grant count", order_q.size(), 6);
    for (int k = 0; k < 6 && k < order_q.size(); k++)
      check(order_q[k] == k % 3, "R6", "round-robin order", order_q[k], k % 3);

    // disjoint pairs with backpressure (R2, R3, R5, R7, R8)
    bp_on = 1;
    for (int i = 0; i < NP; i++) begin
      automatic int ii = i;
      fork run_par(ii); join_none
    end
    wait fork;

    // contention on outputs 9 and 10 with multi-flit bursts (R4, R7)
    for (int i = 0; i < 8; i++) begin
      automatic int ii = i;
      fork run_cont(ii); join_none
    end
    wait fork;

    bp_on = 0;
    repeat (40) @(negedge clk);
    begin
      int left;
      left = 0;
      for (int k = 0; k < NP*NP; k++) left += exp_q[k].size();
      check(left == 0, "R7/R8", "flits never delivered", left, 0);
    end
    check(out_valid == '0, "R7", "outputs drained", longint'(out_valid), 0);
    done = 1;
    finish_run();
  end
endmodule